// File: doc/BRIEF.md
# Profile Detrend and Amplitude Unit

This unit takes one intensity profile of unsigned gray-level pixels. The pixels arrive in index order, with a flag on the first pixel and a flag on the final pixel. The unit fits a least-squares straight line of intensity against pixel index and removes that line from every pixel. The corrected samples leave on a valid/ready stream. One further beat follows them, carrying half the peak-to-peak span of the corrected profile.

A small internal buffer holds the pixels, so the unit can walk the profile several times:

1. The sum of intensities is gathered while the pixels arrive.
2. A sequential divider forms the mean.
3. A covariance pass runs over the buffer.
4. The divider forms the slope.
5. A final pass emits the corrected samples and tracks their extremes.

All index terms use a doubled, centred index u = 2i-(M-1), so the centre (M-1)/2 never needs a fraction. The sum of squared centred indices is not accumulated. It comes from the closed form M(M²-1)/3, which depends only on the length. Values carry FRAC_W fractional bits.

Top module: `prof_detrend`

## Requirements
- R1: After reset, busy is 0, out_valid is 0 and in_ready is 1.
- R2: While idle, a beat without in_start is discarded and leaves busy at 0. A beat with in_start opens a profile as pixel 0. Later beats append pixels, and their in_start is ignored. The profile closes on the beat with in_last, or at the MAX_LEN-th pixel even without in_last.
- R3: From the edge that takes the closing pixel until the amplitude beat is accepted, in_ready is 0 and busy is 1. Once the amplitude beat is accepted, busy returns to 0.
- R4: The mean is mq = floor(S·2^FRAC_W / M), where S is the sum of the M pixels.
- R5: The slope is sq = trunc0(2·C / V). Here C = Σ u_i·(I_i·2^FRAC_W − mq), u_i = 2i−(M−1) and V = M(M²−1)/3. trunc0 rounds toward zero.
- R6: The unit emits M sample beats in index order, each with out_is_amp = 0. Beat i carries d_i = I_i·2^FRAC_W − mq − floor(sq·u_i/2) as an OUT_W-bit two's-complement value.
- R7: After the last sample comes exactly one beat with out_is_amp = 1. Its data is floor((max d − min d)/2), which is never negative.
- R8: For a single-pixel profile the slope divisor V is 0. The slope saturates to 2^DIV_W−1 (2^30−1 at the defaults), the one sample is 0 and the amplitude is 0.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_is_amp hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input pixel beat present |
| in_ready | output | 1 | Unit can take a pixel |
| in_start | input | 1 | Beat is pixel 0 of a profile |
| in_last | input | 1 | Beat closes the profile |
| in_pix | input | PIX_W | Pixel intensity, unsigned |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | OUT_W | Corrected sample or amplitude, signed fixed point |
| out_is_amp | output | 1 | Beat carries the amplitude |
| busy | output | 1 | A profile is in progress |

## Verification
Some properties are checked on every cycle:
- Output stability under back-pressure.
- in_ready falls only right after an accepted input beat.
- The stored length stays within the buffer.
- The tracked minimum never exceeds the maximum, and the amplitude beat is never negative.
- Each divider result satisfies num = q·d + r with r < d, or is all ones when the divisor is zero.

The arithmetic content of the samples and the amplitude can only be shown by the bench scenarios. These sweep every length from 1 to MAX_LEN over ramp, random, flat and alternating patterns, and compare each beat with a model computed from R4 to R7. The same scenarios also exercise the ignored idle beat, the close at full buffer without in_last, and the single-pixel saturation case.

// File: rtl/prof_pkg.sv
package prof_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_DIVM, ST_COV, ST_DIVS, ST_EMIT, ST_AMP
  } prof_state_t;

  // doubled centred index: 2*i - (len-1)
  function automatic int centred_idx(int idx, int len);
    return 2 * idx - len + 1;
  endfunction

  // sum over i of (2i-(len-1))^2, closed form
  function automatic int var2_of(int len);
    return (len * (len * len - 1)) / 3;
  endfunction

endpackage

// File: rtl/prof_buf.sv
module prof_buf #(
  parameter int PIX_W   = 8,
  parameter int MAX_LEN = 32,
  localparam int ADR_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [PIX_W-1:0] wr_data,
  input  logic [ADR_W-1:0] rd_addr,
  output logic [PIX_W-1:0] rd_data
);
  logic [PIX_W-1:0] mem [MAX_LEN];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/seq_div.sv
module seq_div #(
  parameter int W = 30,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);
  logic [W-1:0]  quo_q, rem_q, den_q, num_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, den_zero;
  logic [W:0]    shifted, diff;
  logic          take;

  assign den_zero = (den_q == '0);
  assign shifted  = {rem_q, quo_q[W-1]};
  assign diff     = shifted - {1'b0, den_q};
  assign take     = den_zero | ~diff[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0; rem_q <= '0; den_q <= '0; num_q <= '0;
      cnt_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !busy_q) begin
        quo_q  <= num;
        num_q  <= num;
        den_q  <= den;
        rem_q  <= '0;
        cnt_q  <= CW'(W);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= take ? diff[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], take};
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign quo  = quo_q;
  assign rem  = rem_q;

  // R4
  div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !den_zero |->
      ((2*W)'(quo_q) * (2*W)'(den_q) + (2*W)'(rem_q) == (2*W)'(num_q)) && (rem_q < den_q));

  // R8
  div_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && den_zero |-> (&quo_q));
endmodule

// File: rtl/amp_track.sv
module amp_track #(
  parameter int W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic signed [W-1:0] val,
  output logic        [W-1:0] amp
);
  logic signed [W-1:0] min_q, max_q;
  logic                seen_q;
  logic        [W:0]   span;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q <= '0; max_q <= '0; seen_q <= 1'b0;
    end else if (clr) begin
      seen_q <= 1'b0;
      min_q  <= '0;
      max_q  <= '0;
    end else if (upd) begin
      seen_q <= 1'b1;
      if (!seen_q || val < min_q) min_q <= val;
      if (!seen_q || val > max_q) max_q <= val;
    end
  end

  assign span = {max_q[W-1], max_q} - {min_q[W-1], min_q};
  assign amp  = span[W:1];

  // R7
  minmax_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (min_q <= max_q));
endmodule

// File: rtl/prof_detrend.sv
module prof_detrend
  import prof_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int MAX_LEN = 32,
  parameter int OUT_W   = PIX_W + FRAC_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_start,
  input  logic             in_last,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_is_amp,
  output logic             busy
);
  localparam int CNT_W  = $clog2(MAX_LEN + 1);
  localparam int ADR_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int U_W    = CNT_W + 2;
  localparam int DIV_W  = PIX_W + FRAC_W + 2 * CNT_W + 2;
  localparam int PROD_W = DIV_W + U_W + 4;

  prof_state_t state_q;
  logic [CNT_W-1:0]        len_q, idx_q, cnt_next;
  logic [DIV_W-1:0]        sum_q, mean_q;
  logic signed [DIV_W-1:0] cov_q;
  logic signed [DIV_W:0]   slope_q;
  logic                    div_go_q;

  // named internal events
  logic accept_beat, closing_beat, idx_at_end, emit_fire, amp_fire;
  logic div_busy, div_done;
  logic [DIV_W-1:0] div_num, div_den, div_quo, div_rem;
  logic [PIX_W-1:0] rd_pix;
  logic [ADR_W-1:0] wr_addr;

  // arithmetic views
  logic signed [U_W-1:0]    u_cur;
  logic signed [PROD_W-1:0] pix_w, mean_w, slope_w, u_w, cov_term, d_wide;
  logic                     cov_neg;
  logic [DIV_W-1:0]         cov_mag;
  logic [OUT_W-1:0]         amp_val;
  logic signed [OUT_W-1:0]  d_val;

  assign in_ready     = (state_q == ST_IDLE) || (state_q == ST_LOAD);
  assign busy         = (state_q != ST_IDLE);
  assign accept_beat  = in_valid && in_ready && ((state_q == ST_LOAD) || in_start);
  assign cnt_next     = (state_q == ST_IDLE) ? CNT_W'(1) : len_q + CNT_W'(1);
  assign closing_beat = accept_beat && (in_last || cnt_next == CNT_W'(MAX_LEN));
  assign wr_addr      = (state_q == ST_IDLE) ? '0 : ADR_W'(len_q);
  assign idx_at_end   = (idx_q == len_q - CNT_W'(1));
  assign emit_fire    = (state_q == ST_EMIT) && out_ready;
  assign amp_fire     = (state_q == ST_AMP) && out_ready;

  prof_buf #(.PIX_W(PIX_W), .MAX_LEN(MAX_LEN)) u_buf (
    .clk(clk), .wr_en(accept_beat), .wr_addr(wr_addr), .wr_data(in_pix),
    .rd_addr(ADR_W'(idx_q)), .rd_data(rd_pix)
  );

  assign u_cur    = U_W'(centred_idx(int'(idx_q), int'(len_q)));
  assign u_w      = PROD_W'(u_cur);
  assign pix_w    = PROD_W'({rd_pix, {FRAC_W{1'b0}}});
  assign mean_w   = PROD_W'(mean_q);
  assign slope_w  = PROD_W'(slope_q);
  assign cov_term = u_w * (pix_w - mean_w);
  assign d_wide   = pix_w - mean_w - ((slope_w * u_w) >>> 1);
  assign d_val    = OUT_W'(d_wide);

  assign cov_neg  = cov_q[DIV_W-1];
  assign cov_mag  = cov_neg ? DIV_W'(-cov_q) : DIV_W'(cov_q);
  assign div_num  = (state_q == ST_DIVM) ? (sum_q << FRAC_W) : {cov_mag[DIV_W-2:0], 1'b0};
  assign div_den  = (state_q == ST_DIVM) ? DIV_W'(len_q) : DIV_W'(var2_of(int'(len_q)));

  seq_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go_q), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quo(div_quo), .rem(div_rem)
  );

  amp_track #(.W(OUT_W)) u_amp (
    .clk(clk), .rst_n(rst_n),
    .clr((state_q == ST_DIVS) && div_done),
    .upd(emit_fire), .val(d_val), .amp(amp_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; len_q <= '0; idx_q <= '0; sum_q <= '0;
      mean_q <= '0; cov_q <= '0; slope_q <= '0; div_go_q <= 1'b0;
    end else begin
      div_go_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_LOAD: if (accept_beat) begin
          sum_q <= (state_q == ST_IDLE) ? DIV_W'(in_pix) : sum_q + DIV_W'(in_pix);
          len_q <= cnt_next;
          if (closing_beat) begin
            state_q  <= ST_DIVM;
            div_go_q <= 1'b1;
          end else begin
            state_q <= ST_LOAD;
          end
        end
        ST_DIVM: if (div_done) begin
          mean_q  <= div_quo;
          idx_q   <= '0;
          cov_q   <= '0;
          state_q <= ST_COV;
        end
        ST_COV: begin
          cov_q <= cov_q + DIV_W'(cov_term);
          if (idx_at_end) begin
            idx_q    <= '0;
            state_q  <= ST_DIVS;
            div_go_q <= 1'b1;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        ST_DIVS: if (div_done) begin
          slope_q <= cov_neg ? -$signed({1'b0, div_quo}) : $signed({1'b0, div_quo});
          idx_q   <= '0;
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (out_ready) begin
          if (idx_at_end) state_q <= ST_AMP;
          else idx_q <= idx_q + CNT_W'(1);
        end
        ST_AMP: if (amp_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign out_valid  = (state_q == ST_EMIT) || (state_q == ST_AMP);
  assign out_is_amp = (state_q == ST_AMP);
  assign out_data   = (state_q == ST_AMP) ? amp_val : d_val;

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_amp));

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));

  // R2
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (len_q != '0) && (len_q <= CNT_W'(MAX_LEN)));

  // R7
  amp_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_amp |-> !out_data[OUT_W-1]);

  // R3
  no_div_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_go_q |-> !div_busy && !in_ready);
endmodule

// File: tb/test_prof_detrend.sv
module test_prof_detrend;
  localparam int CLK_NS  = 10;
  localparam int PIX_W   = 8;
  localparam int FRAC_W  = 8;
  localparam int MAX_LEN = 32;
  localparam int OUT_W   = PIX_W + FRAC_W + 4;
  localparam int DIV_W   = PIX_W + FRAC_W + 2 * $clog2(MAX_LEN + 1) + 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_start = 0, in_last = 0, out_ready = 0;
  logic [PIX_W-1:0] in_pix = '0;
  logic in_ready, out_valid, out_is_amp, busy;
  logic [OUT_W-1:0] out_data;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int unsigned seed = 32'h1234_5678;
  int pix [MAX_LEN];
  longint exp_d [MAX_LEN];
  longint exp_amp;

  prof_detrend #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .MAX_LEN(MAX_LEN), .OUT_W(OUT_W)) i_prof_detrend (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_last(in_last), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_is_amp(out_is_amp), .busy(busy)
  );

  always #(CLK_NS / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // model from R4, R5, R6, R7, R8
  task automatic model(int len);
    longint s, mq, c, v, sq, u, mn, mx;
    s = 0;
    for (int i = 0; i < len; i++) s += pix[i];
    mq = (s <<< FRAC_W) / len;
    c = 0;
    for (int i = 0; i < len; i++) c += (2 * i - len + 1) * ((longint'(pix[i]) <<< FRAC_W) - mq);
    v = len * (len * len - 1) / 3;
    sq = (v == 0) ? ((longint'(1) <<< DIV_W) - 1) : (2 * c) / v;
    for (int i = 0; i < len; i++) begin
      u = 2 * i - len + 1;
      exp_d[i] = (longint'(pix[i]) <<< FRAC_W) - mq - ((sq * u) >>> 1);
      if (i == 0 || exp_d[i] < mn) mn = exp_d[i];
      if (i == 0 || exp_d[i] > mx) mx = exp_d[i];
    end
    exp_amp = (mx - mn) >>> 1;
  endtask

  task automatic run_profile(int len, bit use_last);
    int got;
    bit fin, stall, rdy, r3_ok;
    logic [OUT_W-1:0] prev;
    longint act;
    model(len);
    for (int k = 0; k < len; k++) begin
      if (rnd() % 4 == 0) begin
        @(negedge clk); in_valid = 0;
      end
      @(negedge clk);
      in_valid = 1; in_start = (k == 0); in_last = use_last && (k == len - 1);
      in_pix = PIX_W'(pix[k]);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_start = 0; in_last = 0;
    // R3: closed profile refuses input
    chk(!in_ready && busy, "R3 refuse after close", {in_ready, busy}, 2'b01);
    got = 0; fin = 0; stall = 0; r3_ok = 1; prev = '0;
    while (!fin) begin
      @(negedge clk);
      rdy = (rnd() % 3) != 0;
      out_ready = rdy;
      if (in_ready || !busy) r3_ok = 0;
      if (stall) chk(out_valid && out_data == prev, "R9 hold under stall",
                     longint'($signed(out_data)), longint'($signed(prev)));
      if (out_valid && rdy) begin
        act = longint'($signed(out_data));
        if (got < len) begin
          chk(!out_is_amp && act == exp_d[got],
              (len == 1) ? "R8 single-pixel sample" : "R6 sample (R4, R5)", act, exp_d[got]);
          got++;
        end else begin
          chk(out_is_amp && act == exp_amp, (len == 1) ? "R8 amplitude" : "R7 amplitude",
              act, exp_amp);
          fin = 1;
        end
      end
      stall = out_valid && !rdy;
      prev = out_data;
    end
    chk(r3_ok, "R3 busy through output", r3_ok, 1);
    @(negedge clk);
    out_ready = 0;
    chk(!busy && in_ready, "R3 release", busy, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(!busy && !out_valid && in_ready, "R1 reset state", {busy, out_valid, in_ready}, 3'b001);

    // R2: beat without start while idle is discarded
    in_valid = 1; in_start = 0; in_pix = 8'd200;
    @(negedge clk);
    in_valid = 0;
    chk(!busy && in_ready, "R2 idle beat ignored", busy, 0);
    for (int i = 0; i < 5; i++) pix[i] = 10 * i + 3;
    run_profile(5, 1);

    // sweep lengths and patterns (R4 to R9)
    for (int len = 1; len <= MAX_LEN; len++) begin
      for (int pat = 0; pat < 4; pat++) begin
        for (int i = 0; i < len; i++) begin
          case (pat)
            0: pix[i] = (i * 7 + len) % 256;
            1: pix[i] = int'(rnd() % 256);
            2: pix[i] = 77;
            default: pix[i] = (i % 2) ? 255 : 0;
          endcase
        end
        run_profile(len, 1);
      end
    end

    // R2: full buffer closes without in_last
    for (int i = 0; i < MAX_LEN; i++) pix[i] = int'(rnd() % 256);
    run_profile(MAX_LEN, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule